// File: doc/BRIEF.md
# Shared Rounding Stage with Fixed-Priority Arbitration

This block is the single rounding stage that the add, multiply and divide datapaths share. Each datapath offers an unrounded, normalized significand, along with a sign and a biased exponent. It also offers three extra low-order bits (guard, round and sticky), a flag for a denormal operand that an earlier stage found, and a request line. In each cycle one requester is granted access by fixed priority. The granted operands are rounded in the selected mode, renormalized when rounding carries out of the significand, and checked for overflow and inexactness. The result is registered, so rounding costs exactly one cycle.

Results that would be subnormal, and operations whose inputs were flagged as denormal, are not rounded. They raise an unimplemented-operation trap, and system software completes them. A requester that is not granted must keep its request and operands stable until it is granted. The grant is combinational, so a datapath learns in its final cycle whether its value is being taken.

Top module: `shared_rounder`

## Requirements
- R1: Requesters are indexed 0 = add, 1 = multiply, 2 = divide. `gnt` is one-hot or zero and is asserted in the same cycle as the request. It goes to the highest pending index, so divide beats multiply and multiply beats add. A losing requester gets no grant.
- R2: One cycle after a cycle with any request, `out_valid` is 1 and `out_src` holds the granted index. After a cycle with no request, `out_valid` is 0.
- R3: Mode 2'b00 (nearest, ties to even) adds one unit in the last place when guard is 1 and at least one of round, sticky or the significand LSB is 1.
- R4: Mode 2'b01 (toward zero) never increments, so the significand is truncated.
- R5: Mode 2'b10 (toward +infinity) increments when any of guard/round/sticky is 1 and the sign is 0. Mode 2'b11 (toward −infinity) does the same when the sign is 1.
- R6: If the increment carries out of the significand's top bit, the significand is shifted right by one (giving 1 followed by zeros) and the exponent is incremented.
- R7: If the adjusted exponent reaches all ones, `out_ovf` is 1, `out_exp` is all ones and `out_sig` is zero.
- R8: If there is no trap, `out_inx` is 1 exactly when any of guard/round/sticky is 1 or overflow occurs.
- R9: A set denormal flag, or an input exponent of zero, sets `out_trap`. In that case `out_ovf`, `out_inx`, `out_exp` and `out_sig` are all zero, and `out_sign` is passed through.
- R10: While `rst_n` is low, every output register clears to zero at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rmode | input | 2 | Rounding mode (00 nearest-even, 01 zero, 10 +inf, 11 −inf) |
| req | input | 3 | Request per unit (0 add, 1 mul, 2 div) |
| in_sign | input | 3 | Sign per unit |
| in_exp | input | 3*EW | Biased exponent per unit, unit i at [i*EW +: EW] |
| in_sig | input | 3*MW | Normalized significand per unit, unit i at [i*MW +: MW] |
| in_grs | input | 3*3 | Guard/round/sticky per unit, unit i at [i*3 +: 3], guard highest |
| in_den | input | 3 | Denormal-operand flag per unit |
| gnt | output | 3 | One-hot grant, same cycle |
| out_valid | output | 1 | Registered result valid |
| out_src | output | 2 | Index of the unit that produced the result |
| out_sign | output | 1 | Result sign |
| out_exp | output | EW | Result exponent |
| out_sig | output | MW | Rounded significand |
| out_ovf | output | 1 | Overflow flag |
| out_inx | output | 1 | Inexact flag |
| out_trap | output | 1 | Unimplemented-operation trap |

## Verification
Directed operands isolate each decision. Exact ties with an even and with an odd LSB separate ties-to-even from round-half-up. Identical positive and negative operands in the two directed modes expose a swapped sign test. An all-ones significand with guard set forces the carry path, at both a mid-range and the top finite exponent. Random traffic then has all three units contending with held losers, under every mode. It covers both random exponents and zero exponents, which exercises priority order, hold behaviour and the trap path together.

// File: rtl/rnd_pkg.sv
// Package: shared types and constants for the shared rounding stage.
// Assumes three requesters with fixed indices.
package rnd_pkg;
    localparam int NREQ = 3;
    localparam int IDX_W = 2;
    localparam int GRS_W = 3;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_PINF = 2'b10,
        RM_NINF = 2'b11
    } rmode_e;
endpackage

// File: rtl/rnd_arbiter.sv
// Module: fixed-priority arbiter, highest index wins.
// Assumes requesters hold their request until granted; grant is combinational.
module rnd_arbiter #(
    parameter int N = 3,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    logic [N-1:0] higher;

    // Build, per index, whether any higher index is requesting.
    generate
        for (genvar i = 0; i < N; i++) begin : g_pri
            if (i == N - 1) begin : g_top
                assign higher[i] = 1'b0;
            end else begin : g_low
                assign higher[i] = |req[N-1:i+1];
            end
            assign gnt[i] = req[i] & ~higher[i];
        end
    endgenerate

    // Encode the one-hot grant into an index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) idx = IW'(i);
        end
    end

    assign any = |req;

    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
    a_r1_granted_requested: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0);
    a_r1_top_wins: assert property (@(posedge clk) disable iff (!rst_n) req[N-1] |-> gnt[N-1]);
    a_r1_no_idle: assert property (@(posedge clk) disable iff (!rst_n) (|req) |-> (|gnt));
endmodule

// File: rtl/rnd_core.sv
// Module: combinational rounding, renormalization and flag logic.
// Assumes the significand is normalized (MSB set) and the exponent is biased.
module rnd_core
    import rnd_pkg::*;
#(
    parameter int EW = 8,
    parameter int MW = 24
) (
    input  logic [1:0]    mode,
    input  logic          sign,
    input  logic [EW-1:0] exp_i,
    input  logic [MW-1:0] sig_i,
    input  logic [2:0]    grs,
    input  logic          den,
    output logic [EW-1:0] exp_o,
    output logic [MW-1:0] sig_o,
    output logic          ovf,
    output logic          inx,
    output logic          trap
);
    localparam logic [EW:0] EXP_MAX = {1'b0, {EW{1'b1}}};

    logic          lost;
    logic          inc;
    logic [MW:0]   sum;
    logic          carry;
    logic [EW:0]   exp_adj;
    logic [MW-1:0] sig_adj;

    // Decide whether to add one unit in the last place.
    always_comb begin
        lost = |grs;
        unique case (rmode_e'(mode))
            RM_NEAR: inc = grs[2] & (grs[1] | grs[0] | sig_i[0]);
            RM_ZERO: inc = 1'b0;
            RM_PINF: inc = lost & ~sign;
            RM_NINF: inc = lost & sign;
            default: inc = 1'b0;
        endcase
    end

    // Increment and renormalize on carry-out.
    always_comb begin
        sum     = {1'b0, sig_i} + {{MW{1'b0}}, inc};
        carry   = sum[MW];
        sig_adj = carry ? sum[MW:1] : sum[MW-1:0];
        exp_adj = {1'b0, exp_i} + {{EW{1'b0}}, carry};
    end

    // Select trap, overflow or normal result and raise flags.
    always_comb begin
        trap  = den | (exp_i == '0);
        ovf   = 1'b0;
        inx   = 1'b0;
        exp_o = '0;
        sig_o = '0;
        if (!trap) begin
            if (exp_adj >= EXP_MAX) begin
                ovf   = 1'b1;
                inx   = 1'b1;
                exp_o = '1;
            end else begin
                inx   = lost;
                exp_o = exp_adj[EW-1:0];
                sig_o = sig_adj;
            end
        end
    end

    always_comb begin
        a_r9_trap_quiet: assert (!trap || (!ovf && !inx && exp_o == '0 && sig_o == '0));
        a_r4_zero_truncates: assert (mode != 2'b01 || trap || ovf || sig_o == sig_i);
    end
endmodule

// File: rtl/shared_rounder.sv
// Module: top of the shared rounding stage. Arbitrates three datapaths,
// rounds the winner and registers the result (one cycle of latency).
// Assumes losers hold request and operands stable until granted.
module shared_rounder
    import rnd_pkg::*;
#(
    parameter int EW = 8,
    parameter int MW = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            rmode,
    input  logic [NREQ-1:0]       req,
    input  logic [NREQ-1:0]       in_sign,
    input  logic [NREQ*EW-1:0]    in_exp,
    input  logic [NREQ*MW-1:0]    in_sig,
    input  logic [NREQ*GRS_W-1:0] in_grs,
    input  logic [NREQ-1:0]       in_den,
    output logic [NREQ-1:0]       gnt,
    output logic                  out_valid,
    output logic [IDX_W-1:0]      out_src,
    output logic                  out_sign,
    output logic [EW-1:0]         out_exp,
    output logic [MW-1:0]         out_sig,
    output logic                  out_ovf,
    output logic                  out_inx,
    output logic                  out_trap
);
    logic [IDX_W-1:0] sel;
    logic             any_req;
    logic [EW-1:0]    f_exp [NREQ];
    logic [MW-1:0]    f_sig [NREQ];
    logic [2:0]       f_grs [NREQ];
    logic             m_sign, m_den;
    logic [EW-1:0]    m_exp, r_exp;
    logic [MW-1:0]    m_sig, r_sig;
    logic [2:0]       m_grs;
    logic             r_ovf, r_inx, r_trap;

    rnd_arbiter #(.N(NREQ), .IW(IDX_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req),
        .gnt(gnt), .idx(sel), .any(any_req)
    );

    // Slice the flat operand buses per requester.
    generate
        for (genvar i = 0; i < NREQ; i++) begin : g_slice
            assign f_exp[i] = in_exp[i*EW +: EW];
            assign f_sig[i] = in_sig[i*MW +: MW];
            assign f_grs[i] = in_grs[i*GRS_W +: GRS_W];
        end
    endgenerate

    // Steer the granted requester's operands to the rounder.
    always_comb begin
        m_sign = in_sign[sel];
        m_den  = in_den[sel];
        m_exp  = f_exp[sel];
        m_sig  = f_sig[sel];
        m_grs  = f_grs[sel];
    end

    rnd_core #(.EW(EW), .MW(MW)) u_core (
        .mode(rmode), .sign(m_sign), .exp_i(m_exp), .sig_i(m_sig),
        .grs(m_grs), .den(m_den), .exp_o(r_exp), .sig_o(r_sig),
        .ovf(r_ovf), .inx(r_inx), .trap(r_trap)
    );

    // Register the rounded result of the granted requester.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_src   <= '0;
            out_sign  <= 1'b0;
            out_exp   <= '0;
            out_sig   <= '0;
            out_ovf   <= 1'b0;
            out_inx   <= 1'b0;
            out_trap  <= 1'b0;
        end else begin
            out_valid <= any_req;
            out_src   <= sel;
            out_sign  <= m_sign;
            out_exp   <= r_exp;
            out_sig   <= r_sig;
            out_ovf   <= r_ovf;
            out_inx   <= r_inx;
            out_trap  <= r_trap;
        end
    end

    a_r2_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n) (|req) |=> out_valid);
    a_r2_idle_after_none: assert property (@(posedge clk) disable iff (!rst_n) !(|req) |=> !out_valid);
    a_r2_src_top: assert property (@(posedge clk) disable iff (!rst_n) req[NREQ-1] |=> out_src == IDX_W'(NREQ-1));
    a_r7_ovf_saturates: assert property (@(posedge clk) disable iff (!rst_n) out_ovf |-> (out_exp == '1 && out_sig == '0 && out_inx));
    a_r6_norm_kept: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_trap && !out_ovf) |-> out_sig[MW-1]);
endmodule

// File: tb/sim_shared_rounder.sv
module sim_shared_rounder;
    localparam int EW = 8;
    localparam int MW = 24;
    localparam int EMAX = (1 << EW) - 1;

    logic clk = 0;
    logic rst_n = 0;
    logic [1:0] rmode = 0;
    logic [2:0] req = 0;
    logic [2:0] in_sign = 0;
    logic [3*EW-1:0] in_exp;
    logic [3*MW-1:0] in_sig;
    logic [8:0] in_grs;
    logic [2:0] in_den = 0;
    logic [2:0] gnt;
    logic out_valid, out_sign, out_ovf, out_inx, out_trap;
    logic [1:0] out_src;
    logic [EW-1:0] out_exp;
    logic [MW-1:0] out_sig;

    logic [EW-1:0] ex [3];
    logic [MW-1:0] sg [3];
    logic [2:0]    gr [3];

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 3; i++) begin
            in_exp[i*EW +: EW] = ex[i];
            in_sig[i*MW +: MW] = sg[i];
            in_grs[i*3 +: 3]   = gr[i];
        end
    end

    shared_rounder #(.EW(EW), .MW(MW)) u0 (
        .clk(clk), .rst_n(rst_n), .rmode(rmode), .req(req), .in_sign(in_sign),
        .in_exp(in_exp), .in_sig(in_sig), .in_grs(in_grs), .in_den(in_den),
        .gnt(gnt), .out_valid(out_valid), .out_src(out_src), .out_sign(out_sign),
        .out_exp(out_exp), .out_sig(out_sig), .out_ovf(out_ovf), .out_inx(out_inx),
        .out_trap(out_trap)
    );

    task automatic chk(input string tag, input longint act, input longint expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Reference model: returns {trap, ovf, inx, exp, sig}.
    function automatic longint model(input int md, input bit s, input int e,
                                     input longint m, input int g3, input bit d);
        bit g = g3[2], r = g3[1], st = g3[0];
        bit lostb = g | r | st;
        bit up;
        longint v;
        int en;
        if (d || e == 0) return longint'(1) << 34;
        case (md)
            0: up = g && (r || st || m[0]);
            1: up = 0;
            2: up = lostb && !s;
            default: up = lostb && s;
        endcase
        v = m + longint'(up);
        en = e;
        if (v >= (longint'(1) << MW)) begin v = v >> 1; en = en + 1; end
        if (en >= EMAX) return (longint'(3) << 32) | (longint'(EMAX) << MW);
        return (longint'(lostb) << 32) | (longint'(en) << MW) | v;
    endfunction

    function automatic string tag_of(input int md, input longint r, input longint m, input int g3);
        if (r[34]) return "R9";
        if (r[33]) return "R7";
        if (r[MW-1:0] == longint'(1) << (MW-1) && m == (longint'(1) << MW) - 1 && g3 != 0) return "R6";
        case (md) 0: return "R3"; 1: return "R4"; default: return "R5"; endcase
    endfunction

    // Apply current operands for one cycle and check grant and result.
    task automatic step(input bit [2:0] rq, input bit [2:0] dn);
        int w;
        longint e;
        string t;
        @(negedge clk);
        req = rq; in_den = dn;
        #1;
        w = rq[2] ? 2 : rq[1] ? 1 : rq[0] ? 0 : -1;
        chk("R1 gnt", gnt, w < 0 ? 0 : (1 << w));
        if (w >= 0) e = model(rmode, in_sign[w], ex[w], sg[w], gr[w], dn[w]);
        @(negedge clk);
        chk("R2 valid", out_valid, w >= 0);
        if (w >= 0) begin
            t = tag_of(rmode, e, sg[w], gr[w]);
            chk("R2 src", out_src, w);
            chk({t, " result"}, {out_exp, out_sig}, e[EW+MW-1:0]);
            chk("R7 ovf", out_ovf, e[33]);
            chk("R8 inexact", out_inx, e[32]);
            chk("R9 trap", out_trap, e[34]);
            chk("R9 sign", out_sign, in_sign[w]);
        end
    endtask

    task automatic set1(input int i, input bit s, input int e, input longint m, input int g);
        in_sign[i] = s; ex[i] = EW'(e); sg[i] = MW'(m); gr[i] = 3'(g);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit [2:0] rq;
        void'($urandom(32'd1234));
        for (int i = 0; i < 3; i++) set1(i, 0, 100, 24'h800000, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset valid", out_valid, 0);
        chk("R10 reset data", {out_exp, out_sig, out_ovf, out_inx, out_trap}, 0);
        rst_n = 1;

        // R3 ties: even LSB stays, odd LSB rounds up
        rmode = 0;
        set1(0, 0, 100, 24'h800002, 3'b100); step(3'b001, 0);
        set1(0, 0, 100, 24'h800003, 3'b100); step(3'b001, 0);
        set1(0, 0, 100, 24'h800002, 3'b011); step(3'b001, 0);
        // R4 truncate
        rmode = 1; set1(1, 1, 90, 24'h9ABCDE, 3'b111); step(3'b010, 0);
        // R5 sign-directed
        rmode = 2; set1(2, 0, 80, 24'hC00000, 3'b001); step(3'b100, 0);
        set1(2, 1, 80, 24'hC00000, 3'b001); step(3'b100, 0);
        rmode = 3; step(3'b100, 0);
        set1(2, 0, 80, 24'hC00000, 3'b001); step(3'b100, 0);
        // R6 carry, R7 overflow via carry at top exponent
        rmode = 0; set1(0, 0, 120, 24'hFFFFFF, 3'b110); step(3'b001, 0);
        set1(0, 0, EMAX - 1, 24'hFFFFFF, 3'b110); step(3'b001, 0);
        // R9 trap: zero exponent and denormal flag
        set1(1, 1, 0, 24'h800001, 3'b100); step(3'b010, 0);
        set1(1, 0, 50, 24'h800001, 3'b100); step(3'b010, 3'b010);
        // R1 priority and R2 idle
        step(3'b111, 0); step(3'b011, 0); step(3'b000, 0);

        // Random contention with held losers.
        rq = 0;
        for (int n = 0; n < 3000; n++) begin
            int w;
            for (int i = 0; i < 3; i++)
                if (!rq[i]) begin
                    int e = ($urandom_range(9) == 0) ? 0 :
                            ($urandom_range(9) == 0) ? EMAX - 1 : $urandom_range(EMAX - 1, 1);
                    longint m = ($urandom_range(5) == 0) ? 24'hFFFFFF : (24'h800000 | $urandom_range(24'h7FFFFF));
                    set1(i, $urandom_range(1), e, m, $urandom_range(7));
                    rq[i] = $urandom_range(1);
                end
            rmode = 2'($urandom_range(3));
            step(rq, 3'($urandom_range(15) == 0 ? $urandom_range(7) : 0));
            w = rq[2] ? 2 : rq[1] ? 1 : rq[0] ? 0 : -1;
            if (w >= 0) rq[w] = 0;
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule